// File: doc/BRIEF.md
# CSR Access Checker and Read-Modify-Write Sequencer

This block is the shared front end that every control/status register instruction passes through. It takes the kind of operation (plain read, write, bit-set or bit-clear), the 12-bit register address, the instruction operand and the current privilege level. From these it decides whether the access is allowed, reads the old value through a simple storage port, merges the operand into it under a write mask, and raises a write strobe toward the storage when the merged value has to be written back.

Legality comes from three places. The first is the address itself: two bits give the lowest privilege that may touch the register, and two bits mark it as read-only. The second is the storage port, which reports whether an address is implemented. The third applies only to the user-visible counter pages: a per-counter enable built by ANDing the machine and supervisor enable masks in a chain, depending on how far below machine level the current mode is. The whole decision, the old-value return and the write strobe are produced in the same cycle as the request. The block holds no state.

There is no state machine. The path runs straight from decode to gating to merge. The storage behind `rf_*` keeps the register contents.

Top module: `csr_access_front`

## Requirements
- R1: The lowest privilege allowed to access a register is `req_addr[9:8]`. Privilege is encoded U=0, S=1, M=3. A request is illegal when `cur_priv` is numerically lower than that field.
- R2: A register is read-only when `req_addr[11:10]` is 3. A request to it with a nonzero write mask is illegal. A zero-mask request is legal, including a set or clear with a zero operand.
- R3: The counter pages are the addresses whose bits [11:5] equal 0x60 or 0x64. For these, the enable starts at all ones. It is ANDed with `mcounter_en` when `cur_priv` is below M, and also with `scounter_en` when `cur_priv` is below S. The request is illegal when the enable bit selected by `req_addr[4:0]` is clear. Slots at or above `NCNT` count as clear.
- R4: `req_op` encodes 0 = read (mask zero), 1 = write (mask all ones, data = operand), 2 = set (mask = operand, data all ones) and 3 = clear (mask = operand, data zero).
- R5: `rf_wdata` equals (old AND NOT mask) OR (data AND mask). `rf_we` is high in the request cycle exactly when the request is valid, legal and the mask is nonzero.
- R6: `rsp_old` returns `rf_rdata` for a valid legal request. It is zero for an illegal request or when no request is valid.
- R7: A request to an address for which the storage reports `rf_hit` low is illegal.
- R8: An illegal request never raises `rf_we`. With `req_valid` low, both `rf_we` and `rsp_illegal` are low.
- R9: `rf_addr` carries `req_addr` in the same cycle, so the storage read happens combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation kind: 0 read, 1 write, 2 set, 3 clear |
| req_addr | input | 12 | Register address |
| req_operand | input | XLEN | Instruction operand |
| cur_priv | input | 2 | Current privilege, U=0, S=1, M=3 |
| mcounter_en | input | NCNT | Machine-level counter enable mask |
| scounter_en | input | NCNT | Supervisor-level counter enable mask |
| rf_addr | output | 12 | Address presented to the register storage |
| rf_rdata | input | XLEN | Current value read from the storage |
| rf_hit | input | 1 | Storage implements the addressed register |
| rf_we | output | 1 | Write strobe to the storage |
| rf_wdata | output | XLEN | Merged value to be written |
| rsp_old | output | XLEN | Old value returned to the instruction |
| rsp_illegal | output | 1 | Request raises an illegal-instruction fault |

## Verification
The bench builds the block with its defaults, XLEN=32 and NCNT=32. At that size the whole 4096-entry address space can be swept under each of the three privilege levels and all four operation kinds. The sweep reaches every privilege field and both read-only and writable pages. It also covers every one of the 32 slots of both counter pages. Enable masks, stored values, operands and the unimplemented pattern are derived arithmetically from the address, so each slot sees different enable bits. Zero operands recur on a fixed address stride, which brings the zero-mask set and clear cases on read-only registers within reach. Directed cases cover the idle state and the chained enable in each mode.

// File: rtl/csr_front_pkg.sv
package csr_front_pkg;

    localparam int CSR_ADDR_W = 12;
    localparam int CNT_SLOTS  = 32;
    localparam int CNT_IDX_W  = $clog2(CNT_SLOTS);
    localparam int PAGE_W     = CSR_ADDR_W - CNT_IDX_W;

    localparam logic [PAGE_W-1:0] CNT_LO_PAGE = 7'h60;
    localparam logic [PAGE_W-1:0] CNT_HI_PAGE = 7'h64;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic [1:0]           min_priv;
        logic                 read_only;
        logic                 is_counter;
        logic [CNT_IDX_W-1:0] cnt_idx;
    } addr_info_t;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_front_pkg::*;
(
    input  logic [CSR_ADDR_W-1:0] addr,
    output addr_info_t            info
);

    logic [PAGE_W-1:0] page;

    assign page = addr[CSR_ADDR_W-1:CNT_IDX_W];

    always_comb begin
        info.min_priv   = addr[9:8];
        info.read_only  = &addr[11:10];
        info.is_counter = (page == CNT_LO_PAGE) || (page == CNT_HI_PAGE);
        info.cnt_idx    = addr[CNT_IDX_W-1:0];
    end

endmodule

// File: rtl/csr_counter_gate.sv
module csr_counter_gate
    import csr_front_pkg::*;
#(
    parameter int NCNT = 32
) (
    input  logic [1:0]           cur_priv,
    input  logic [NCNT-1:0]      mcen,
    input  logic [NCNT-1:0]      scen,
    input  logic [CNT_IDX_W-1:0] idx,
    output logic                 allowed
);

    logic below_mach;
    logic below_super;
    logic [CNT_SLOTS-1:0] slot_en;

    assign below_mach  = cur_priv < 2'(PRV_MACH);
    assign below_super = cur_priv < 2'(PRV_SUPER);

    // Chained enable per slot: machine mask first, supervisor mask second.
    for (genvar i = 0; i < CNT_SLOTS; i++) begin : g_slot
        if (i < NCNT) begin : g_present
            assign slot_en[i] = (~below_mach  | mcen[i]) &
                                (~below_super | scen[i]);
        end else begin : g_absent
            assign slot_en[i] = 1'b0;
        end
    end

    assign allowed = slot_en[idx];

endmodule

// File: rtl/csr_op_expand.sv
module csr_op_expand
    import csr_front_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] wmask,
    output logic [XLEN-1:0] wval
);

    always_comb begin
        unique case (csr_op_e'(op))
            OP_READ: begin
                wmask = '0;
                wval  = '0;
            end
            OP_WRITE: begin
                wmask = '1;
                wval  = operand;
            end
            OP_SET: begin
                wmask = operand;
                wval  = '1;
            end
            OP_CLEAR: begin
                wmask = operand;
                wval  = '0;
            end
            default: begin
                wmask = '0;
                wval  = '0;
            end
        endcase
    end

endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge #(
    parameter int XLEN = 32
) (
    input  logic            valid,
    input  logic            illegal,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wmask,
    input  logic [XLEN-1:0] wval,
    output logic            we,
    output logic [XLEN-1:0] merged
);

    assign merged = (old_val & ~wmask) | (wval & wmask);
    assign we     = valid & ~illegal & (|wmask);

endmodule

// File: rtl/csr_access_front.sv
module csr_access_front
    import csr_front_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NCNT = 32
) (
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [CSR_ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]       req_operand,
    input  logic [1:0]            cur_priv,
    input  logic [NCNT-1:0]       mcounter_en,
    input  logic [NCNT-1:0]       scounter_en,
    output logic [CSR_ADDR_W-1:0] rf_addr,
    input  logic [XLEN-1:0]       rf_rdata,
    input  logic                  rf_hit,
    output logic                  rf_we,
    output logic [XLEN-1:0]       rf_wdata,
    output logic [XLEN-1:0]       rsp_old,
    output logic                  rsp_illegal
);

    addr_info_t      info;
    logic            cnt_allowed;
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] wval;
    logic            priv_low;
    logic            ro_viol;
    logic            cnt_viol;
    logic            fault;

    csr_addr_decode u_decode (
        .addr (req_addr),
        .info (info)
    );

    csr_counter_gate #(.NCNT(NCNT)) u_gate (
        .cur_priv (cur_priv),
        .mcen     (mcounter_en),
        .scen     (scounter_en),
        .idx      (info.cnt_idx),
        .allowed  (cnt_allowed)
    );

    csr_op_expand #(.XLEN(XLEN)) u_expand (
        .op      (req_op),
        .operand (req_operand),
        .wmask   (wmask),
        .wval    (wval)
    );

    // Fault sources are independent; any one of them blocks the access.
    assign priv_low = cur_priv < info.min_priv;
    assign ro_viol  = info.read_only & (|wmask);
    assign cnt_viol = info.is_counter & ~cnt_allowed;
    assign fault    = ~rf_hit | priv_low | ro_viol | cnt_viol;

    csr_rmw_merge #(.XLEN(XLEN)) u_merge (
        .valid   (req_valid),
        .illegal (fault),
        .old_val (rf_rdata),
        .wmask   (wmask),
        .wval    (wval),
        .we      (rf_we),
        .merged  (rf_wdata)
    );

    assign rf_addr     = req_addr;
    assign rsp_illegal = req_valid & fault;
    assign rsp_old     = (req_valid & ~fault) ? rf_rdata : '0;

endmodule

// File: rtl/csr_access_front_chk.sv
module csr_access_front_chk #(
    parameter int XLEN = 32,
    parameter int NCNT = 32
) (
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [11:0]     req_addr,
    input logic [XLEN-1:0] req_operand,
    input logic [1:0]      cur_priv,
    input logic [NCNT-1:0] mcounter_en,
    input logic [11:0]     rf_addr,
    input logic [XLEN-1:0] rf_rdata,
    input logic            rf_hit,
    input logic            rf_we,
    input logic [XLEN-1:0] rf_wdata,
    input logic [XLEN-1:0] rsp_old,
    input logic            rsp_illegal
);

    always_comb begin
        if (req_valid && (cur_priv < req_addr[9:8]))
            p_priv_floor_r1: assert (rsp_illegal)
                else $error("privilege floor not enforced");

        if (rf_we)
            p_ro_no_write_r2: assert (req_addr[11:10] != 2'b11)
                else $error("write to read-only register");

        if (req_valid && cur_priv == 2'd0 && req_addr[11:5] == 7'h60 &&
            32'(req_addr[4:0]) < NCNT && !mcounter_en[req_addr[4:0]])
            p_cnt_gate_r3: assert (rsp_illegal)
                else $error("counter gate not enforced");

        if (rf_we && req_op == 2'd1)
            p_write_data_r4: assert (rf_wdata == req_operand)
                else $error("write data wrong");
        if (rf_we && req_op == 2'd2)
            p_set_data_r4: assert (rf_wdata == (rf_rdata | req_operand))
                else $error("set data wrong");
        if (rf_we && req_op == 2'd3)
            p_clear_data_r4: assert (rf_wdata == (rf_rdata & ~req_operand))
                else $error("clear data wrong");

        if (req_op == 2'd0 || (req_op[1] && req_operand == '0))
            p_zero_mask_r5: assert (!rf_we)
                else $error("write with zero mask");

        if (req_valid && !rsp_illegal)
            p_old_pass_r6: assert (rsp_old == rf_rdata)
                else $error("old value not returned");
        if (rsp_illegal)
            p_old_zero_r6: assert (rsp_old == '0)
                else $error("old value leaked on fault");

        if (req_valid && !rf_hit)
            p_unimpl_r7: assert (rsp_illegal)
                else $error("unimplemented register accepted");

        if (rsp_illegal || !req_valid)
            p_fault_blocks_r8: assert (!rf_we)
                else $error("write strobe while blocked");
        if (!req_valid)
            p_idle_quiet_r8: assert (!rsp_illegal)
                else $error("fault without request");

        p_addr_fwd_r9: assert (rf_addr == req_addr)
            else $error("storage address mismatch");
    end

endmodule

bind csr_access_front csr_access_front_chk #(.XLEN(XLEN), .NCNT(NCNT)) u_chk (
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_operand (req_operand),
    .cur_priv    (cur_priv),
    .mcounter_en (mcounter_en),
    .rf_addr     (rf_addr),
    .rf_rdata    (rf_rdata),
    .rf_hit      (rf_hit),
    .rf_we       (rf_we),
    .rf_wdata    (rf_wdata),
    .rsp_old     (rsp_old),
    .rsp_illegal (rsp_illegal)
);

// File: tb/csr_access_front_bench.sv
module csr_access_front_bench;

    logic        clk = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_operand = '0;
    logic [1:0]  cur_priv = '0;
    logic [31:0] mcounter_en = '0;
    logic [31:0] scounter_en = '0;
    logic [11:0] rf_addr;
    logic [31:0] rf_rdata = '0;
    logic        rf_hit = 1'b0;
    logic        rf_we;
    logic [31:0] rf_wdata;
    logic [31:0] rsp_old;
    logic        rsp_illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    csr_access_front u_csr_access_front (
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_operand (req_operand),
        .cur_priv    (cur_priv),
        .mcounter_en (mcounter_en),
        .scounter_en (scounter_en),
        .rf_addr     (rf_addr),
        .rf_rdata    (rf_rdata),
        .rf_hit      (rf_hit),
        .rf_we       (rf_we),
        .rf_wdata    (rf_wdata),
        .rsp_old     (rsp_old),
        .rsp_illegal (rsp_illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h op=%0d priv=%0d act=%h exp=%h",
                     tag, req_addr, req_op, cur_priv, act, exp);
        end
    endtask

    // Reference built from the requirement text.
    task automatic apply(input logic [1:0] op, input logic [11:0] a, input logic [31:0] opd,
                         input logic [1:0] pv, input logic [31:0] mc, input logic [31:0] sc,
                         input logic hit, input logic [31:0] old);
        logic [31:0] mask, val, en, wd;
        logic        ill, we;
        string       why;
        @(posedge clk);
        req_valid   = 1'b1;
        req_op      = op;
        req_addr    = a;
        req_operand = opd;
        cur_priv    = pv;
        mcounter_en = mc;
        scounter_en = sc;
        rf_hit      = hit;
        rf_rdata    = old;
        // R4 op expansion
        case (op)
            2'd0:    begin mask = '0;  val = '0;  end
            2'd1:    begin mask = '1;  val = opd; end
            2'd2:    begin mask = opd; val = '1;  end
            default: begin mask = opd; val = '0;  end
        endcase
        // R3 chained enable
        en = '1;
        if (pv < 2'd3) en = en & mc;
        if (pv < 2'd1) en = en & sc;
        why = "";
        if (!hit)                                         why = "R7";
        else if (pv < a[9:8])                             why = "R1";
        else if (a[11:10] == 2'b11 && mask != 0)          why = "R2";
        else if ((a[11:5] == 7'h60 || a[11:5] == 7'h64) && !en[a[4:0]]) why = "R3";
        ill = (why != "");
        we  = !ill && (mask != 0);
        wd  = (old & ~mask) | (val & mask);
        @(negedge clk);
        check(ill ? why : "R1 legal", 32'(rsp_illegal), 32'(ill));
        check(ill ? "R8" : "R5", 32'(rf_we), 32'(we));
        if (we) check("R5 merge", rf_wdata, wd);
        check("R6", rsp_old, ill ? 32'h0 : old);
        check("R9", 32'(rf_addr), 32'(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Idle state: nothing requested (R8)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 idle we", 32'(rf_we), 32'h0);
        check("R8 idle illegal", 32'(rsp_illegal), 32'h0);
        check("R6 idle old", rsp_old, 32'h0);

        // Directed corners
        apply(2'd2, 12'hC00, 32'h0, 2'd3, 32'h0, 32'h0, 1'b1, 32'h1234_5678); // R2 zero-mask set legal
        apply(2'd3, 12'hF11, 32'h0, 2'd3, 32'h0, 32'h0, 1'b1, 32'hCAFE_0001); // R2 zero-mask clear legal
        apply(2'd1, 12'hF11, 32'h0, 2'd3, 32'h0, 32'h0, 1'b1, 32'hCAFE_0001); // R2 write illegal
        apply(2'd0, 12'hC02, 32'h0, 2'd3, 32'h0, 32'h0, 1'b1, 32'h0000_0042); // R3 machine ignores masks
        apply(2'd0, 12'hC02, 32'h0, 2'd1, 32'hFFFF_FFFB, 32'hFFFF_FFFF, 1'b1, 32'h7); // R3 S blocked by mc
        apply(2'd0, 12'hC02, 32'h0, 2'd1, 32'h0000_0004, 32'h0, 1'b1, 32'h7); // R3 S ignores sc
        apply(2'd0, 12'hC82, 32'h0, 2'd0, 32'h0000_0004, 32'h0, 1'b1, 32'h7); // R3 U blocked by sc
        apply(2'd0, 12'hC82, 32'h0, 2'd0, 32'h0000_0004, 32'h4, 1'b1, 32'h7); // R3 U both set
        apply(2'd1, 12'h340, 32'hA5A5_5A5A, 2'd1, 32'h0, 32'h0, 1'b1, 32'h1); // R1 S below M
        apply(2'd2, 12'h340, 32'h0000_00F0, 2'd3, 32'h0, 32'h0, 1'b1, 32'h0F0F_0F0F); // R4 set
        apply(2'd3, 12'h340, 32'h0000_000F, 2'd3, 32'h0, 32'h0, 1'b1, 32'h0F0F_0F0F); // R4 clear
        apply(2'd1, 12'h100, 32'h1, 2'd1, 32'h0, 32'h0, 1'b0, 32'h99); // R7 unimplemented

        // Full sweep: every address, privilege and op
        for (int a = 0; a < 4096; a++) begin
            for (int p = 0; p < 3; p++) begin
                for (int o = 0; o < 4; o++) begin
                    logic [1:0]  pv;
                    logic [31:0] mc, sc, opd, old;
                    pv  = (p == 2) ? 2'd3 : 2'(p);
                    mc  = 32'h9E37_79B9 * 32'(a + 1);
                    sc  = 32'h7F4A_7C15 ^ (32'(a) << 3) ^ 32'(o);
                    opd = (a % 8 == 0) ? 32'h0 : (32'hC3A5_0000 | 32'(a) | (32'(o) << 12));
                    old = (32'(a) * 32'h0101_0101) ^ 32'h5A5A_0000;
                    apply(2'(o), 12'(a), opd, pv, mc, sc, (a % 16) != 15, old);
                end
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        check("R8 final idle", 32'(rf_we | rsp_illegal), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule